// File: doc/BRIEF.md
# Two-Slot Morse Message Recorder

The recorder stores and replays two short Morse keying messages, one bit per element period, into two single-bit-wide message memories. It is fed by the element-rate strobe that also paces the paddle keyer, so every stored bit stands for exactly one element period. The live keyer output is the data source.

A single address counter serves both slots. Pressing a slot button presets the counter: slot 1 to zero, slot 2 to a value whose top bit is set. The top counter bit then selects the memory. While the button is held, the counter stays at that start value. After release, each element tick moves the counter on by one. When the carry reaches the bit just above the memory address, the counter freezes and both memories are deselected.

The mode level chooses what a button press does. With the level high, the sweep records the live key bit. With it low, the sweep plays the stored bits back on the memory key output. Active-low run indicators show which slot is running, and an active-low stop indicator shows the idle state.

Top module: `morse_msg_rec`

## Requirements
- R1: After reset the recorder is stopped: `stop_n` is 0, `run1_n` and `run2_n` are 1, and `mem_key` is 0.
- R2: While `load1` is high, the counter is held at 0 whatever `tick` does, so slot 1 is selected with address 0. `run1_n` reads 0, and the sweep starts at address 0 only after release.
- R3: While `load2` is high and `load1` is low, the counter is held at 2*DEPTH (top bit set, address 0), so slot 2 is selected. `run2_n` reads 0, and the sweep starts at address 0 of slot 2 after release.
- R4: When both buttons are high, `load1` wins and slot 1 is selected.
- R5: While running with no button held, each clock with `tick` high advances the address by one, and a clock with `tick` low leaves it unchanged.
- R6: Exactly DEPTH ticks after release, the counter stops: `stop_n` goes to 0, both run indicators go to 1, and further ticks neither move the counter nor write.
- R7: With `prog` high, a running slot and no button held, each tick writes `key_in` into the selected slot at the current address before the address advances. No write happens while a button is held or while stopped.
- R8: With `prog` low and running, `mem_key` equals the bit stored at the current address of the selected slot. `mem_key` is 0 while stopped or while `prog` is high.
- R9: Recording into one slot leaves the other slot's contents unchanged.
- R10: At most one of the two memory enables is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Element-rate strobe, one clock wide |
| key_in | input | 1 | Live keyer output bit (recording source) |
| load1 | input | 1 | Slot 1 button, active high |
| load2 | input | 1 | Slot 2 button, active high |
| prog | input | 1 | 1 = record on button press, 0 = play back |
| mem_key | output | 1 | Replayed key bit |
| run1_n | output | 1 | Slot 1 running, active low |
| run2_n | output | 1 | Slot 2 running, active low |
| stop_n | output | 1 | Counter stopped, active low |

## Verification
The bench builds the recorder with ADDR_W = 4, which gives 16-entry slots. Every record and playback pass can therefore run to the end-of-memory stop, and the freeze after stop can be checked many times within a short run. The same slot layout, with the top counter bit as slot select and the carry bit as stop, applies at the default depth of 1024. Random key patterns and random idle gaps between ticks exercise the address advance. Directed cases cover held buttons with ticks, both buttons pressed at once, ticks after stop, and a reset in the middle of a sweep.

// File: rtl/morse_msg_rec.sv
module morse_msg_rec #(
  parameter int ADDR_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic key_in,
  input  logic load1,
  input  logic load2,
  input  logic prog,
  output logic mem_key,
  output logic run1_n,
  output logic run2_n,
  output logic stop_n
);
  localparam int CW = ADDR_W + 2;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [CW-1:0] STOP_VAL  = CW'(DEPTH);
  localparam logic [CW-1:0] SLOT2_VAL = CW'(2 * DEPTH);

  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr;
  logic              stop, slot, run, held, wr, ce1, ce2, rd;
  logic              mem1 [DEPTH];
  logic              mem2 [DEPTH];

  assign addr = cnt[ADDR_W-1:0];
  assign stop = cnt[ADDR_W];
  assign slot = cnt[CW-1];
  assign run  = ~stop;
  assign held = load1 | load2;
  assign ce1  = run & ~slot;
  assign ce2  = run & slot;
  assign wr   = prog & tick & ~held;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= STOP_VAL;
    else if (load1)      cnt <= '0;
    else if (load2)      cnt <= SLOT2_VAL;
    else if (tick & run) cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (wr & ce1) mem1[addr] <= key_in;
    if (wr & ce2) mem2[addr] <= key_in;
  end

  assign rd      = slot ? mem2[addr] : mem1[addr];
  assign mem_key = run & ~prog & rd;
  assign run1_n  = ~ce1;
  assign run2_n  = ~ce2;
  assign stop_n  = ~stop;

  p_load1_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load1 |=> cnt == '0);
  p_load2_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load2 && !load1) |=> cnt == SLOT2_VAL);
  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !held) |=> cnt == $past(cnt) + CW'(1));
  p_end_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !held && (&addr)) |=> stop);
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !held) |=> $stable(cnt));
  p_one_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ce1, ce2}));
endmodule

// File: tb/morse_msg_rec_tb.sv
module morse_msg_rec_tb;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic clk = 0, rst_n = 0, tick = 0, key_in = 0, load1 = 0, load2 = 0, prog = 0;
  logic mem_key, run1_n, run2_n, stop_n;
  int   vectors = 0, fails = 0;
  bit   done = 0;
  bit   e1 [N];
  bit   e2 [N];

  always #5 clk = ~clk;

  morse_msg_rec #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .key_in(key_in), .load1(load1),
    .load2(load2), .prog(prog), .mem_key(mem_key), .run1_n(run1_n),
    .run2_n(run2_n), .stop_n(stop_n));

  function automatic bit expbit(int s, int i);
    return (s == 2) ? e2[i] : e1[i];
  endfunction

  task automatic chk(string r, logic a, logic e);
    vectors++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", r, a, e, $time);
    end
  endtask

  task automatic cyc(logic tk, logic kb);
    tick = tk; key_in = kb;
    @(posedge clk); @(negedge clk);
    tick = 0;
  endtask

  task automatic stopped_chk(string r);
    chk(r, stop_n, 1'b0); chk(r, run1_n, 1'b1); chk(r, run2_n, 1'b1); chk(r, mem_key, 1'b0);
  endtask

  task automatic press(bit b1, bit b2, int nt);
    load1 = b1; load2 = b2;
    for (int k = 0; k < nt; k++) cyc(1'b1, 1'($urandom));
    chk("R2/R3 run during hold", run1_n, !b1 && b2 ? 1'b1 : 1'b0);
    chk("R3/R4 run during hold", run2_n, !b1 && b2 ? 1'b0 : 1'b1);
    load1 = 0; load2 = 0;
  endtask

  task automatic record(int s);
    prog = 1;
    press(s == 1, s == 2, 1 + ($urandom % 3));
    for (int i = 0; i < N; i++) begin
      bit b = 1'($urandom);
      if (s == 2) e2[i] = b; else e1[i] = b;
      for (int g = $urandom % 3; g > 0; g--) cyc(1'b0, ~b);
      chk("R6 not stopped early", stop_n, 1'b1);
      chk("R8 no output while recording", mem_key, 1'b0);
      cyc(1'b1, b);
    end
    stopped_chk("R6 stop after record");
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'($urandom));
    stopped_chk("R6 frozen after record");
  endtask

  task automatic play(int s, bit b1, bit b2);
    prog = 0;
    press(b1, b2, 1 + ($urandom % 3));
    for (int i = 0; i < N; i++) begin
      for (int g = $urandom % 3; g > 0; g--) begin
        chk("R5 idle no advance", mem_key, expbit(s, i));
        cyc(1'b0, 1'b0);
      end
      chk(s == 1 ? "R8 slot1 play" : "R8 slot2 play", mem_key, expbit(s, i));
      cyc(1'b1, 1'b0);
    end
    stopped_chk("R6 stop after play");
    cyc(1'b1, 1'b1);
    stopped_chk("R6 ticks after stop");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    stopped_chk("R1 reset state");
    rst_n = 1;
    cyc(1'b1, 1'b1);
    stopped_chk("R1 idle after reset");

    record(1);
    record(2);
    play(1, 1'b1, 1'b0);
    play(2, 1'b0, 1'b1);

    // R9: rewrite slot 1, slot 2 must be untouched
    record(1);
    play(2, 1'b0, 1'b1);
    play(1, 1'b1, 1'b0);

    // R4: both buttons, slot 1 wins
    play(1, 1'b1, 1'b1);

    // R7: held button with ticks writes nothing; mode dropped before release
    prog = 1; load1 = 1;
    for (int k = 0; k < 4; k++) cyc(1'b1, ~e1[0]);
    chk("R7 held run1", run1_n, 1'b0);
    prog = 0;
    cyc(1'b0, 1'b0);
    chk("R7 no write while held", mem_key, e1[0]);
    load1 = 0;
    for (int i = 0; i < N; i++) begin
      chk("R7 slot1 intact", mem_key, e1[i]);
      cyc(1'b1, 1'b0);
    end
    stopped_chk("R6 stop after held test");

    // R7: ticks in record mode while stopped must not write (stop address aliases slot 1 addr 0)
    prog = 1;
    for (int k = 0; k < 4; k++) cyc(1'b1, ~e1[0]);
    play(1, 1'b1, 1'b0);

    // R2: long hold with ticks still starts at address 0
    prog = 0;
    press(1'b1, 1'b0, 7);
    chk("R2 start at addr0 after hold", mem_key, e1[0]);
    cyc(1'b1, 1'b0);
    chk("R5 one step", mem_key, e1[1]);

    // R1: reset in mid sweep
    rst_n = 0;
    cyc(1'b0, 1'b0);
    stopped_chk("R1 reset mid sweep");
    rst_n = 1;
    cyc(1'b1, 1'b0);
    stopped_chk("R1 stays stopped");

    done = 1;
    finish_run();
  end
endmodule